// File: doc/BRIEF.md
# ADC conversion timing sequencer

This block produces the phase strobes that pace a successive-approximation converter. It divides the peripheral clock into a conversion clock with one of eight ratios, including the non-power-of-two ratios 6 and 5. A conversion is started either by software or by a hardware trigger. A trigger-started conversion is preceded by a power-supply settling wait. The block then counts the sampling phase and the bit-decision phase. The lengths of these phases depend on which of two low-voltage modes is chosen and on whether 10-bit or 8-bit results are wanted.

The divider ratio, mode, resolution and sequencing choice are captured only while both the start and the enable controls are low. They are held unchanged at all other times. In sequential mode, one conversion follows the previous one with no gap and no further settling wait. The sequence ends when software releases its start control or when enable is cleared. Clearing enable stops any activity at once.

Top module: `adc_seq_timer`

## Requirements
- R1: Divider select code 000 gives a conversion tick every 64 clocks. The other codes map as 001→32, 010→16, 011→8, 100→6, 101→5, 110→4 and 111→2. Ticks inside a running conversion are evenly spaced, so consecutive `step_o` pulses are exactly one ratio apart.
- R2: A rising edge of `start_i` accepted while idle with `enable_i` high raises `busy_o` on the next clock. No settling wait is inserted. `done_o` follows after (total ticks × ratio) clocks, counted from the edge on which the input was driven.
- R3: In mode 1 (`lv_mode_i`=0) at 10 bits (`res8_i`=0), a conversion is 19 ticks. The first 7 ticks are sampling (`sample_o` high), and the 12 ticks after them are the bit phase (`convert_o` high, one `step_o` per tick).
- R4: In mode 2 (`lv_mode_i`=1) at 10 bits, a conversion is 17 ticks, of which 5 are sampling and 12 are the bit phase.
- R5: 8-bit resolution (`res8_i`=1) removes two ticks from the bit phase in either mode. The bit phase then gives 10 `step_o` pulses, and the sampling length is unchanged.
- R6: A rising edge of `hw_trig_i` accepted while idle with `enable_i` high and no start edge starts a 2-tick settling wait. The conversion follows the wait, so the total from trigger to `done_o` is (2 + conversion ticks) × ratio clocks.
- R7: In sequential mode (`seq_mode_i`=1) after a trigger start, each later conversion begins right after the previous `done_o`. The spacing between dones is conversion ticks × ratio, and `busy_o` stays high between conversions.
- R8: In sequential mode after a software start, conversions repeat back to back while `start_i` stays high. If `start_i` is low at a `done_o`, `busy_o` is low on the next clock.
- R9: Divider, mode, resolution and sequencing inputs are captured only on clocks where both `start_i` and `enable_i` are low. Changes at other times have no effect on tick spacing or conversion length.
- R10: A `hw_trig_i` edge while `busy_o` is high is ignored. It neither changes the running conversion nor starts another one afterwards.
- R11: With `enable_i` low, `busy_o` and every strobe are low by the next clock, whatever phase was running.
- R12: `done_o` is a one-clock pulse, given together with the last `step_o` of a conversion and only while `busy_o` is high. In one-shot mode `busy_o` falls on the clock after it.
- R13: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Converter enable; low aborts and idles |
| start_i | input | 1 | Software start (rising edge), held high to continue a sequence |
| hw_trig_i | input | 1 | Hardware trigger (rising edge) |
| seq_mode_i | input | 1 | 1 = sequential, 0 = one-shot |
| div_sel_i | input | 3 | Conversion clock divider select |
| lv_mode_i | input | 1 | 0 = low-voltage mode 1, 1 = low-voltage mode 2 |
| res8_i | input | 1 | 1 = 8-bit, 0 = 10-bit resolution |
| sample_o | output | 1 | High during the sampling phase |
| convert_o | output | 1 | High during the bit-decision phase |
| step_o | output | 1 | One-clock strobe per bit-phase tick |
| done_o | output | 1 | One-clock pulse ending a conversion |
| busy_o | output | 1 | High from acceptance to the end of a conversion or sequence |

## Verification
A divider count that is off shows at the ports on the next tick. The `step_o` spacing, or the delay to the first strobe, moves by whole clocks within one conversion-clock period. A phase counter or phase register that is wrong shows as a `sample_o` window or bit-phase length off by whole ticks, or as a `done_o` that comes early or late. It can also show as a busy flag that drops or persists one conversion early or late. The bench runs a behavioural model in lockstep, so the first clock at which any of the five outputs disagrees is reported. Directed measurements then check the tick counts of each phase, in every mode, against the arithmetic of the requirements.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   localparam int unsigned DIV_SEL_W = 3;
   localparam int unsigned MAX_RATIO = 64;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_STAB = 2'd1,
      PH_SAMP = 2'd2,
      PH_CONV = 2'd3
   } phase_e;

   typedef struct packed {
      logic [DIV_SEL_W-1:0] div_sel;
      logic                 lv2;
      logic                 res8;
      logic                 seq;
   } cfg_t;

   // peripheral clocks per conversion tick for a divider code
   function automatic int unsigned ratio_of(input logic [DIV_SEL_W-1:0] sel);
      case (sel)
         3'd0:    return 64;
         3'd1:    return 32;
         3'd2:    return 16;
         3'd3:    return 8;
         3'd4:    return 6;
         3'd5:    return 5;
         3'd6:    return 4;
         default: return 2;
      endcase
   endfunction

endpackage

// File: rtl/adc_seq_div.sv
module adc_seq_div #(
   parameter int unsigned CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             tick_o
);

   logic [CNT_W-1:0] cnt_q;

   // down-counter reloading at ratio-1; held at reload while not running
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       cnt_q <= '0;
      else if (!run_i || cnt_q == '0)    cnt_q <= reload_i;
      else                               cnt_q <= cnt_q - CNT_W'(1);
   end

   assign tick_o = run_i && (cnt_q == '0);

endmodule

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg
   import adc_seq_pkg::*;
#(
   parameter int unsigned N_EDGE = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              enable_i,
   input  cfg_t              cfg_i,
   input  logic [N_EDGE-1:0] lvl_i,
   output cfg_t              cfg_o,
   output logic [N_EDGE-1:0] rise_o
);

   cfg_t cfg_q;

   // settings follow the inputs only while fully stopped
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cfg_q <= '0;
      else if (!start_i && !enable_i) cfg_q <= cfg_i;
   end

   assign cfg_o = cfg_q;

   for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) prev_q <= 1'b0;
         else         prev_q <= lvl_i[g];
      end
      assign rise_o[g] = lvl_i[g] && !prev_q;
   end

endmodule

// File: rtl/adc_seq_phase.sv
module adc_seq_phase
   import adc_seq_pkg::*;
#(
   parameter int unsigned PH_W       = 5,
   parameter int unsigned STAB_TICKS = 2,
   parameter int unsigned LV1_TOTAL  = 19,
   parameter int unsigned LV1_SAMP   = 7,
   parameter int unsigned LV2_TOTAL  = 17,
   parameter int unsigned LV2_SAMP   = 5,
   parameter int unsigned RES8_CUT   = 2
) (
   input  logic   clk_i,
   input  logic   rst_ni,
   input  logic   tick_i,
   input  logic   enable_i,
   input  logic   sw_go_i,
   input  logic   hw_go_i,
   input  logic   start_lvl_i,
   input  cfg_t   cfg_i,
   output phase_e phase_o,
   output logic   done_o
);

   phase_e          ph_q, ph_d;
   logic [PH_W-1:0] pc_q, pc_d;
   logic            trig_q, trig_d;
   logic [PH_W-1:0] tot_len, samp_len, conv_len, lim;
   logic            last;

   always_comb begin
      tot_len  = cfg_i.lv2 ? PH_W'(LV2_TOTAL) : PH_W'(LV1_TOTAL);
      if (cfg_i.res8) tot_len = tot_len - PH_W'(RES8_CUT);
      samp_len = cfg_i.lv2 ? PH_W'(LV2_SAMP) : PH_W'(LV1_SAMP);
      conv_len = tot_len - samp_len;
      case (ph_q)
         PH_STAB: lim = PH_W'(STAB_TICKS);
         PH_SAMP: lim = samp_len;
         default: lim = conv_len;
      endcase
   end

   assign last = tick_i && (pc_q == lim - PH_W'(1));

   always_comb begin
      ph_d   = ph_q;
      pc_d   = pc_q;
      trig_d = trig_q;
      if (!enable_i) begin
         ph_d = PH_IDLE;
         pc_d = '0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (sw_go_i) begin
                  ph_d   = PH_SAMP;
                  pc_d   = '0;
                  trig_d = 1'b0;
               end else if (hw_go_i) begin
                  ph_d   = (STAB_TICKS == 0) ? PH_SAMP : PH_STAB;
                  pc_d   = '0;
                  trig_d = 1'b1;
               end
            end
            PH_STAB: begin
               if (last) begin
                  ph_d = PH_SAMP;
                  pc_d = '0;
               end else if (tick_i) begin
                  pc_d = pc_q + PH_W'(1);
               end
            end
            PH_SAMP: begin
               if (last) begin
                  ph_d = PH_CONV;
                  pc_d = '0;
               end else if (tick_i) begin
                  pc_d = pc_q + PH_W'(1);
               end
            end
            default: begin
               if (last) begin
                  pc_d = '0;
                  ph_d = (cfg_i.seq && (trig_q || start_lvl_i)) ? PH_SAMP : PH_IDLE;
               end else if (tick_i) begin
                  pc_d = pc_q + PH_W'(1);
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ph_q   <= PH_IDLE;
         pc_q   <= '0;
         trig_q <= 1'b0;
      end else begin
         ph_q   <= ph_d;
         pc_q   <= pc_d;
         trig_q <= trig_d;
      end
   end

   assign phase_o = ph_q;
   assign done_o  = (ph_q == PH_CONV) && last;

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
   import adc_seq_pkg::*;
#(
   parameter int unsigned STAB_TICKS = 2,
   parameter int unsigned LV1_TOTAL  = 19,
   parameter int unsigned LV1_SAMP   = 7,
   parameter int unsigned LV2_TOTAL  = 17,
   parameter int unsigned LV2_SAMP   = 5,
   parameter int unsigned RES8_CUT   = 2
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 enable_i,
   input  logic                 start_i,
   input  logic                 hw_trig_i,
   input  logic                 seq_mode_i,
   input  logic [DIV_SEL_W-1:0] div_sel_i,
   input  logic                 lv_mode_i,
   input  logic                 res8_i,
   output logic                 sample_o,
   output logic                 convert_o,
   output logic                 step_o,
   output logic                 done_o,
   output logic                 busy_o
);

   localparam int unsigned CNT_W   = $clog2(MAX_RATIO);
   localparam int unsigned LONGEST = (LV1_TOTAL > LV2_TOTAL) ? LV1_TOTAL : LV2_TOTAL;
   localparam int unsigned PH_W    = $clog2(LONGEST + 1);

   // elaboration-time parameter checks
   if (LV1_SAMP + RES8_CUT >= LV1_TOTAL) begin : g_bad_lv1
      $error("mode 1 sampling leaves no bit phase");
   end
   if (LV2_SAMP + RES8_CUT >= LV2_TOTAL) begin : g_bad_lv2
      $error("mode 2 sampling leaves no bit phase");
   end
   if (STAB_TICKS >= (1 << PH_W)) begin : g_bad_stab
      $error("settling wait too long for phase counter");
   end

   cfg_t        cfg_in, cfg_q;
   logic [1:0]  lvl, rise;
   phase_e      phase;
   logic        run, tick, done;
   logic [CNT_W-1:0] reload;

   assign cfg_in = '{div_sel: div_sel_i, lv2: lv_mode_i, res8: res8_i, seq: seq_mode_i};
   assign lvl    = {hw_trig_i, start_i};

   adc_seq_cfg #(.N_EDGE(2)) cfg_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start_i),
      .enable_i (enable_i),
      .cfg_i    (cfg_in),
      .lvl_i    (lvl),
      .cfg_o    (cfg_q),
      .rise_o   (rise)
   );

   assign run    = (phase != PH_IDLE);
   assign reload = CNT_W'(ratio_of(cfg_q.div_sel) - 1);

   adc_seq_div #(.CNT_W(CNT_W)) div_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run),
      .reload_i (reload),
      .tick_o   (tick)
   );

   adc_seq_phase #(
      .PH_W       (PH_W),
      .STAB_TICKS (STAB_TICKS),
      .LV1_TOTAL  (LV1_TOTAL),
      .LV1_SAMP   (LV1_SAMP),
      .LV2_TOTAL  (LV2_TOTAL),
      .LV2_SAMP   (LV2_SAMP),
      .RES8_CUT   (RES8_CUT)
   ) phase_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .enable_i    (enable_i),
      .sw_go_i     (rise[0]),
      .hw_go_i     (rise[1]),
      .start_lvl_i (start_i),
      .cfg_i       (cfg_q),
      .phase_o     (phase),
      .done_o      (done)
   );

   assign busy_o    = run;
   assign sample_o  = (phase == PH_SAMP);
   assign convert_o = (phase == PH_CONV);
   assign step_o    = convert_o && tick;
   assign done_o    = done;

endmodule

// File: rtl/adc_seq_timer_chk.sv
module adc_seq_timer_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic enable_i,
   input logic sample_o,
   input logic convert_o,
   input logic step_o,
   input logic done_o,
   input logic busy_o
);

   // R12
   done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> busy_o);

   // R12
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R11
   abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enable_i |=> !busy_o);

   // R3
   phase_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({sample_o, convert_o}));

   // R5
   step_in_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      step_o |-> convert_o);

   // R2
   idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !(sample_o || convert_o || step_o));

endmodule

bind adc_seq_timer adc_seq_timer_chk chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .enable_i  (enable_i),
   .sample_o  (sample_o),
   .convert_o (convert_o),
   .step_o    (step_o),
   .done_o    (done_o),
   .busy_o    (busy_o)
);

// File: tb/adc_seq_timer_tb.sv
module adc_seq_timer_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic enable_i = 0, start_i = 0, hw_trig_i = 0, seq_mode_i = 0;
   logic [2:0] div_sel_i = 0;
   logic lv_mode_i = 0, res8_i = 0;
   logic sample_o, convert_o, step_o, done_o, busy_o;

   int n_cmp = 0;
   int n_bad = 0;

   adc_seq_timer dut_i (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable_i), .start_i(start_i),
      .hw_trig_i(hw_trig_i), .seq_mode_i(seq_mode_i), .div_sel_i(div_sel_i),
      .lv_mode_i(lv_mode_i), .res8_i(res8_i), .sample_o(sample_o),
      .convert_o(convert_o), .step_o(step_o), .done_o(done_o), .busy_o(busy_o)
   );

   function automatic int f_ratio(input int sel);
      int tbl[8] = '{64, 32, 16, 8, 6, 5, 4, 2};
      return tbl[sel];
   endfunction
   function automatic int f_tot(input bit lv, input bit r8);
      return (lv ? 17 : 19) - (r8 ? 2 : 0);
   endfunction
   function automatic int f_samp(input bit lv);
      return lv ? 5 : 7;
   endfunction

   // behavioural reference model: 0 idle, 1 settle, 2 sample, 3 bit phase
   int m_state = 0, m_cnt = 0, m_pc = 0;
   int m_div = 0;
   bit m_lv = 0, m_r8 = 0, m_seq = 0, m_sq = 0, m_tq = 0, m_tseq = 0;

   always @(posedge clk) begin
      int rr, cl, sl, lim, ns, npc;
      bit tk;
      if (!rst_n) begin
         m_state = 0; m_cnt = 0; m_pc = 0; m_div = 0;
         m_lv = 0; m_r8 = 0; m_seq = 0; m_sq = 0; m_tq = 0; m_tseq = 0;
      end else begin
         rr = f_ratio(m_div);
         sl = f_samp(m_lv);
         cl = f_tot(m_lv, m_r8) - sl;
         tk = (m_state != 0) && (m_cnt == 0);
         lim = (m_state == 1) ? 2 : (m_state == 2) ? sl : cl;
         ns = m_state; npc = m_pc;
         if (m_state == 0 || m_cnt == 0) m_cnt = rr - 1; else m_cnt = m_cnt - 1;
         if (!enable_i) ns = 0;
         else if (m_state == 0) begin
            if (start_i && !m_sq) begin ns = 2; npc = 0; m_tseq = 0; end
            else if (hw_trig_i && !m_tq) begin ns = 1; npc = 0; m_tseq = 1; end
         end else if (tk) begin
            if (m_pc == lim - 1) begin
               npc = 0;
               if (m_state == 1) ns = 2;
               else if (m_state == 2) ns = 3;
               else ns = (m_seq && (m_tseq || start_i)) ? 2 : 0;
            end else npc = m_pc + 1;
         end
         m_state = ns; m_pc = npc;
         if (!start_i && !enable_i) begin
            m_div = div_sel_i; m_lv = lv_mode_i; m_r8 = res8_i; m_seq = seq_mode_i;
         end
         m_sq = start_i; m_tq = hw_trig_i;
      end
   end

   task automatic cmp_bit(input string tag, input string nm, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s lockstep %s at %0t: actual %b expected %b", tag, nm, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      bit e_busy, e_tick, e_step;
      if (rst_n) begin
         e_busy = (m_state != 0);
         e_tick = e_busy && (m_cnt == 0);
         e_step = (m_state == 3) && e_tick;
         cmp_bit("R12", "busy_o", busy_o, e_busy);
         cmp_bit("R3", "sample_o", sample_o, m_state == 2);
         cmp_bit("R5", "convert_o", convert_o, m_state == 3);
         cmp_bit("R1", "step_o", step_o, e_step);
         cmp_bit("R12", "done_o", done_o,
                 e_step && (m_pc == f_tot(m_lv, m_r8) - f_samp(m_lv) - 1));
      end
   end

   task automatic chk_int(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic finish_sim();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic cfg(input int dv, input bit lv, input bit r8, input bit sq);
      @(negedge clk);
      enable_i = 0; start_i = 0; hw_trig_i = 0;
      div_sel_i = 3'(dv); lv_mode_i = lv; res8_i = r8; seq_mode_i = sq;
      @(negedge clk);
      enable_i = 1;
      @(negedge clk);
   endtask

   task automatic run_conv(input bit use_trig, input int poke_at,
                           output int cyc, output int samp, output int steps, output int gap);
      int last;
      last = -1; cyc = 0; samp = 0; steps = 0; gap = 0;
      @(negedge clk);
      if (use_trig) hw_trig_i = 1; else start_i = 1;
      while (cyc < 20000) begin
         @(negedge clk);
         cyc++;
         hw_trig_i = (cyc == poke_at);
         if (sample_o) samp++;
         if (step_o) begin
            if (last >= 0) gap = cyc - last;
            last = cyc;
            steps++;
         end
         if (done_o) break;
      end
      hw_trig_i = 0;
      start_i = 0;
   endtask

   task automatic wait_done(output int cyc, output bit busy_ok);
      cyc = 0; busy_ok = 1;
      while (cyc < 20000) begin
         @(negedge clk);
         cyc++;
         if (!busy_o) busy_ok = 0;
         if (done_o) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      int cyc, samp, steps, gap, rr;
      bit bok;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk_int("R13", "outputs in reset", {sample_o, convert_o, step_o, done_o, busy_o}, 0);
      rst_n = 1;
      @(negedge clk);
      chk_int("R13", "outputs after reset", {sample_o, convert_o, step_o, done_o, busy_o}, 0);

      // R1 / R2: every divider code, mode 1, 10-bit, software start
      for (int s = 0; s < 8; s++) begin
         rr = f_ratio(s);
         cfg(s, 0, 0, 0);
         run_conv(0, 0, cyc, samp, steps, gap);
         chk_int("R1", $sformatf("step spacing sel %0d", s), gap, rr);
         chk_int("R2", $sformatf("start-to-done sel %0d", s), cyc, 19 * rr);
         @(negedge clk);
         chk_int("R12", "done one clock, busy falls", {done_o, busy_o}, 0);
      end
      // R3 phase split in mode 1, 10-bit (ratio 2 from last loop pass)
      chk_int("R3", "sampling clocks", samp, 7 * 2);
      chk_int("R3", "bit steps", steps, 12);

      // R4 mode 2, 10-bit
      cfg(3, 1, 0, 0);
      run_conv(0, 0, cyc, samp, steps, gap);
      chk_int("R4", "total", cyc, 17 * 8);
      chk_int("R4", "sampling clocks", samp, 5 * 8);
      chk_int("R4", "bit steps", steps, 12);

      // R5 8-bit in both modes
      cfg(3, 0, 1, 0);
      run_conv(0, 0, cyc, samp, steps, gap);
      chk_int("R5", "mode1 8-bit total", cyc, 17 * 8);
      chk_int("R5", "mode1 8-bit steps", steps, 10);
      chk_int("R5", "mode1 8-bit sampling", samp, 7 * 8);
      cfg(4, 1, 1, 0);
      run_conv(0, 0, cyc, samp, steps, gap);
      chk_int("R5", "mode2 8-bit total", cyc, 15 * 6);
      chk_int("R5", "mode2 8-bit steps", steps, 10);

      // R6 hardware trigger with settling wait
      cfg(2, 0, 0, 0);
      run_conv(1, 0, cyc, samp, steps, gap);
      chk_int("R6", "trigger-to-done", cyc, 21 * 16);
      chk_int("R6", "sampling clocks", samp, 7 * 16);
      cfg(5, 1, 1, 0);
      run_conv(1, 0, cyc, samp, steps, gap);
      chk_int("R6", "trigger-to-done mode2 8-bit", cyc, 17 * 5);

      // R10 trigger during busy ignored
      cfg(6, 0, 0, 0);
      run_conv(0, 20, cyc, samp, steps, gap);
      chk_int("R10", "length with stray trigger", cyc, 19 * 4);
      repeat (3) begin
         @(negedge clk);
         chk_int("R10", "no conversion from stray trigger", busy_o, 0);
      end

      // R9 setting changes while enabled are ignored
      cfg(7, 0, 0, 0);
      @(negedge clk);
      div_sel_i = 3'd0; lv_mode_i = 1; res8_i = 1;
      run_conv(0, 0, cyc, samp, steps, gap);
      chk_int("R9", "spacing kept", gap, 2);
      chk_int("R9", "length kept", cyc, 19 * 2);

      // R7 sequential trigger run
      cfg(5, 0, 0, 1);
      run_conv(1, 0, cyc, samp, steps, gap);
      chk_int("R7", "first done with settling", cyc, 21 * 5);
      wait_done(cyc, bok);
      chk_int("R7", "second done spacing", cyc, 19 * 5);
      chk_int("R7", "busy held between", bok, 1);
      enable_i = 0;
      @(negedge clk);
      chk_int("R11", "abort of sequence", {busy_o, sample_o, convert_o}, 0);

      // R8 sequential software run
      cfg(7, 1, 0, 1);
      start_i = 1;
      wait_done(cyc, bok);
      chk_int("R8", "first done", cyc, 17 * 2);
      wait_done(cyc, bok);
      chk_int("R8", "back-to-back done", cyc, 17 * 2);
      chk_int("R8", "busy held", bok, 1);
      start_i = 0;
      @(negedge clk);
      chk_int("R8", "sequence ends on start low", busy_o, 0);

      // R11 abort during bit phase and during settling
      cfg(4, 0, 0, 0);
      start_i = 1;
      repeat (60) @(negedge clk);
      chk_int("R11", "in bit phase before abort", convert_o, 1);
      enable_i = 0;
      @(negedge clk);
      chk_int("R11", "idle after abort", {busy_o, convert_o, step_o}, 0);
      cfg(1, 0, 0, 0);
      hw_trig_i = 1;
      repeat (3) @(negedge clk);
      hw_trig_i = 0;
      chk_int("R11", "settling busy", {busy_o, sample_o}, 2);
      enable_i = 0;
      @(negedge clk);
      chk_int("R11", "idle after settle abort", busy_o, 0);

      repeat (4) @(negedge clk);
      finish_sim();
   end

endmodule